// File: doc/BRIEF.md
# Maskable Interrupt Pending Router

This block gathers the eight level-sensitive interrupt requests produced by the channels of one I/O board. It does not create those requests. Three serial channels each supply a receive source and a transmit source, and two parallel ports supply one source each. Every request is copied into a pending register on each clock. That copy can always be read, whatever the masks hold. Two enable registers, one for the receive-side group and one for the transmit-side group, let the host suppress sources it does not want. Reset clears both enable registers, so every source starts out disabled.

Each enabled, pending source is routed to any subset of eight vectored interrupt lines. The routing comes from a static 8×8 configuration matrix, which takes the place of board jumpers. The lines are active low and model open-collector wiring. A line is pulled low when at least one source routed to it is both pending and enabled, so several sources sharing a line combine as a wired-OR. The host reaches the registers through a small port with a 2-bit select, a write strobe, write data, and combinational read data.

Source numbering: receive sources of serial channels 0..2 are bits 0..2, parallel port A is bit 3, transmit sources of serial channels 0..2 are bits 4..6, and parallel port B is bit 7.

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-low reset, the pending register reads 0, both enable registers read 0, and all eight `irq_n` lines are high.
- R2: Pending bit i equals `req[i]` as sampled at the previous rising clock edge. It drops one cycle after the request drops, whatever the enables hold.
- R3: With `sel` = 0, `rd_data` returns the full pending vector regardless of the enable settings.
- R4: A write with `sel` = 1 loads `wdata[3:0]` as the enables of sources 0..3, with bit j enabling source j and 1 meaning enabled. Reading `sel` = 1 returns those four bits in `rd_data[3:0]`, and `rd_data[7:4]` reads 0.
- R5: A write with `sel` = 2 loads `wdata[3:0]` as the enables of sources 4..7, with bit j enabling source 4+j. Reading `sel` = 2 returns them in `rd_data[3:0]`, and `rd_data[7:4]` reads 0.
- R6: A write with `sel` = 0 or `sel` = 3 changes no register. Both enable registers read back unchanged afterwards.
- R7: With `sel` = 3, `rd_data` returns pending AND enable, with bit i holding source i.
- R8: `irq_n[k]` is low exactly when some source i has its pending bit, its enable bit, and `route_cfg[i*8+k]` all set. Otherwise the line is high.
- R9: One source routed to several lines pulls all of those lines low at once. Clearing its enable releases every one of them on the clock edge that ends the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 8 | Level-sensitive interrupt requests from the on-board sources |
| route_cfg | input | 64 | Routing matrix; bit i*8+k connects source i to line k |
| wr_en | input | 1 | Register write strobe |
| sel | input | 2 | Register select: 0 pending, 1 receive enables, 2 transmit enables, 3 enabled pending |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| irq_n | output | 8 | Active-low vectored interrupt lines |

## Verification
The assertions assume that `route_cfg` is static or changes only between checks, because it stands in for jumpers. They also assume that `req`, `sel`, `wr_en` and `wdata` change only away from the rising edge. The bench drives every input shortly after a rising edge and holds it for at least one full cycle. It changes the routing map only while it is not sampling. It sweeps all 256 request patterns under several routing maps and enable settings, so the invariants in the assertions are always met.

// File: rtl/irq_router_pkg.sv
// Package: shared register-select encoding for the interrupt router.
// Assumes a 2-bit register select on the host port.
package irq_router_pkg;
    typedef enum logic [1:0] {
        SEL_PEND   = 2'd0,
        SEL_RX_EN  = 2'd1,
        SEL_TX_EN  = 2'd2,
        SEL_ACTIVE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_pend_reg.sv
// Module: irq_pend_reg
// Registers a copy of the level-sensitive requests each clock.
// Assumes the requests are synchronous to clk. No masking is applied here.
module irq_pend_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    output logic [W-1:0] pend
);
    // Sample the requests; synchronous reset clears the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= req;
    end
endmodule

// File: rtl/irq_enable_regs.sv
// Module: irq_enable_regs
// Holds two half-width enable registers, one for the lower (receive-side)
// sources and one for the upper (transmit-side) sources.
// Assumes W is even. Writes to other selects leave both registers unchanged.
module irq_enable_regs
    import irq_router_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    localparam int HALF = W / 2;

    logic [HALF-1:0] lo_en;
    logic [HALF-1:0] hi_en;

    // Load the lower-group enables on a write to the receive select.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lo_en <= '0;
        else if (wr_en && sel == SEL_RX_EN)  lo_en <= wdata[HALF-1:0];
    end

    // Load the upper-group enables on a write to the transmit select.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hi_en <= '0;
        else if (wr_en && sel == SEL_TX_EN)  hi_en <= wdata[HALF-1:0];
    end

    assign en = {hi_en, lo_en};
endmodule

// File: rtl/irq_route_matrix.sv
// Module: irq_route_matrix
// Drives active-low lines from the active sources through a routing matrix.
// Bit i*N_LINE+k of route_cfg joins source i to line k (wired-OR model).
// Assumes route_cfg is quasi-static, as jumpers would be.
module irq_route_matrix #(
    parameter int N_SRC  = 8,
    parameter int N_LINE = 8
) (
    input  logic [N_SRC-1:0]        active,
    input  logic [N_SRC*N_LINE-1:0] route_cfg,
    output logic [N_LINE-1:0]       irq_n
);
    genvar k;
    generate
        for (k = 0; k < N_LINE; k++) begin : g_line
            logic [N_SRC-1:0] hit;
            genvar i;
            for (i = 0; i < N_SRC; i++) begin : g_src
                assign hit[i] = active[i] & route_cfg[i*N_LINE + k];
            end
            // Pull the line low when any routed source is active.
            assign irq_n[k] = ~(|hit);
        end
    endgenerate
endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Pending capture, split enable registers, read mux and routing onto
// active-low vectored lines. Assumes N_SRC is even and fits the read width.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int N_LINE = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC*N_LINE-1:0] route_cfg,
    input  logic                    wr_en,
    input  logic [1:0]              sel,
    input  logic [N_SRC-1:0]        wdata,
    output logic [N_SRC-1:0]        rd_data,
    output logic [N_LINE-1:0]       irq_n
);
    localparam int HALF = N_SRC / 2;

    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] en;
    logic [N_SRC-1:0] active;
    reg_sel_e         sel_e;

    assign sel_e  = reg_sel_e'(sel);
    assign active = pend & en;

    irq_pend_reg #(.W(N_SRC)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req),
        .pend (pend)
    );

    irq_enable_regs #(.W(N_SRC)) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .sel  (sel_e),
        .wdata(wdata),
        .en   (en)
    );

    irq_route_matrix #(.N_SRC(N_SRC), .N_LINE(N_LINE)) u_route (
        .active   (active),
        .route_cfg(route_cfg),
        .irq_n    (irq_n)
    );

    // Select the register returned to the host.
    always_comb begin
        unique case (sel_e)
            SEL_PEND:   rd_data = pend;
            SEL_RX_EN:  rd_data = {{(N_SRC-HALF){1'b0}}, en[HALF-1:0]};
            SEL_TX_EN:  rd_data = {{(N_SRC-HALF){1'b0}}, en[N_SRC-1:HALF]};
            SEL_ACTIVE: rd_data = active;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_router_chk.sv
// Module: irq_router_chk
// Assertion checker bound to irq_router. Assumes inputs change away from
// the rising edge and route_cfg is static while checks are made.
module irq_router_chk #(
    parameter int N_SRC  = 8,
    parameter int N_LINE = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [1:0]              sel,
    input logic [N_SRC-1:0]        req,
    input logic [N_SRC-1:0]        pend,
    input logic [N_SRC-1:0]        en,
    input logic [N_SRC-1:0]        rd_data,
    input logic [N_LINE-1:0]       irq_n
);
    localparam int HALF = N_SRC / 2;

    // R1: leaving reset, nothing is pending or enabled and all lines idle.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend == '0 && en == '0 && irq_n == '1));

    // R2: pending tracks the request sampled one edge earlier.
    p_pend_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend == $past(req));

    // R3: pending read returns the pending register.
    p_rd_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'd0 |-> rd_data == pend);

    // R4/R5: enable reads have zero upper half.
    p_en_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd1 || sel == 2'd2) |-> rd_data[N_SRC-1:HALF] == '0);

    // R6: writes to read-only selects keep the enables.
    p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == 2'd0 || sel == 2'd3)) |=> $stable(en));

    // R8: no active source means every line is released.
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & en) == '0 |-> irq_n == '1);
endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_LINE(N_LINE)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .sel    (sel),
    .req    (req),
    .pend   (pend),
    .en     (en),
    .rd_data(rd_data),
    .irq_n  (irq_n)
);

// File: tb/tb_irq_router.sv
// Bench for irq_router: sweeps every request pattern under several routing
// maps and enable settings, with expected values computed in the bench.
module tb_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NL = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   req = '0;
    logic [NS*NL-1:0] route_cfg = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      sel = 2'd0;
    logic [NS-1:0]   wdata = '0;
    logic [NS-1:0]   rd_data;
    logic [NL-1:0]   irq_n;

    int total = 0;
    int bad = 0;
    logic [NS-1:0] en_m = '0;

    irq_router #(.N_SRC(NS), .N_LINE(NL)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .route_cfg(route_cfg),
        .wr_en(wr_en), .sel(sel), .wdata(wdata), .rd_data(rd_data),
        .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic route_bit(input int m, input int i, input int k);
        case (m)
            0: return (i == k);
            1: return 1'b1;
            2: return ((i*3 + k*5 + 1) % 4) == 0;
            default: return (k == 7 - i) || (k == (i + 1) % 8);
        endcase
    endfunction

    function automatic logic [NL-1:0] exp_irq(input logic [NS-1:0] p,
                                               input logic [NS-1:0] e,
                                               input logic [NS*NL-1:0] r);
        logic [NL-1:0] o = '1;
        for (int k = 0; k < NL; k++)
            for (int i = 0; i < NS; i++)
                if (p[i] && e[i] && r[i*NL+k]) o[k] = 1'b0;
        return o;
    endfunction

    task automatic check(input string tag, input logic [NS-1:0] act,
                         input logic [NS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
        wr_en = 1'b1; sel = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (a == 2'd1) en_m[3:0] = d[3:0];
        if (a == 2'd2) en_m[7:4] = d[3:0];
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a,
                            input logic [NS-1:0] exp);
        sel = a; #1;
        check(tag, rd_data, exp);
    endtask

    task automatic set_req(input logic [NS-1:0] v);
        req = v;
        @(posedge clk); #1;
    endtask

    task automatic load_map(input int m);
        for (int i = 0; i < NS; i++)
            for (int k = 0; k < NL; k++)
                route_cfg[i*NL+k] = route_bit(m, i, k);
    endtask

    initial begin
        logic [NS-1:0] en_list [5];
        en_list[0] = 8'h00; en_list[1] = 8'hFF; en_list[2] = 8'h0F;
        en_list[3] = 8'hF0; en_list[4] = 8'h5A;

        load_map(1);
        req = 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        req = '0;
        // R1: reset state
        check("R1 irq_n", irq_n, 8'hFF);
        rd_check("R1 rx_en", 2'd1, 8'h00);
        rd_check("R1 tx_en", 2'd2, 8'h00);
        @(posedge clk); #1;
        rd_check("R1 pend", 2'd0, 8'h00);

        // R4 / R5: enable register write and read-back
        wr(2'd1, 8'hF5);
        rd_check("R4 rx_en", 2'd1, 8'h05);
        wr(2'd2, 8'hAC);
        rd_check("R5 tx_en", 2'd2, 8'h0C);
        rd_check("R4 rx_en held", 2'd1, 8'h05);

        // R6: writes to read-only selects are ignored
        wr(2'd0, 8'hFF);
        wr(2'd3, 8'hFF);
        rd_check("R6 rx_en", 2'd1, 8'h05);
        rd_check("R6 tx_en", 2'd2, 8'h0C);
        set_req(8'hFF);
        rd_check("R6 active", 2'd3, 8'hC5);

        // R2: pending drops one cycle after request drops
        set_req(8'h00);
        rd_check("R2 pend drop", 2'd0, 8'h00);
        check("R2 irq_n idle", irq_n, 8'hFF);

        // Sweep: maps x enables x all request patterns (R2 R3 R7 R8)
        for (int m = 0; m < 4; m++) begin
            load_map(m);
            for (int e = 0; e < 5; e++) begin
                wr(2'd1, {4'h0, en_list[e][3:0]});
                wr(2'd2, {4'h0, en_list[e][7:4]});
                for (int v = 0; v < 256; v++) begin
                    set_req(v[7:0]);
                    check("R8 irq_n", irq_n, exp_irq(v[7:0], en_m, route_cfg));
                    if (v % 16 == 3) begin
                        rd_check("R3 pend", 2'd0, v[7:0]);
                        rd_check("R7 active", 2'd3, v[7:0] & en_m);
                    end
                end
            end
        end

        // R9: one source to lines 0, 3, 7; masking it releases all of them
        route_cfg = '0;
        route_cfg[2*NL+0] = 1'b1;
        route_cfg[2*NL+3] = 1'b1;
        route_cfg[2*NL+7] = 1'b1;
        wr(2'd1, 8'h0F);
        set_req(8'h04);
        check("R9 fan-out", irq_n, 8'h76);
        wr(2'd1, 8'h0B);
        check("R9 masked", irq_n, 8'hFF);
        rd_check("R9 still pending", 2'd0, 8'h04);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule